// File: doc/BRIEF.md
# Immediate-Operand Instruction Executor

This unit runs one 32-bit instruction per start pulse, taken from a family of opcodes that all carry a 32-bit immediate value. It pulls instruction bytes one at a time from a byte-wide code port addressed by its own instruction pointer. It classifies the opcode and takes an operand-selector (ModR/M) byte when the opcode has one. It then gathers the four immediate bytes, least significant byte first.

The result goes to one of eight 32-bit registers or to a 32-bit word in data memory. Data memory sits behind a synchronous word port, and a register supplies the memory address. Sign, zero and overflow flags are kept and exported, and one register can be observed through a read-only view port.

The supported work is arithmetic and logic with an immediate (add, or, and, subtract, xor), compare, move-immediate and push-immediate. Any opcode, sub-operation or addressing mode outside that set stops the unit with a sticky error.

Top module: `imm_exec_unit`

## Requirements
- R1: After synchronous active-low reset, all eight registers, the three flags and the instruction pointer read zero, and `done` and `err` are low.
- R2: The immediate is assembled little-endian, so the bytes 0a 0b 0c 0d mean 0x0d0c0b0a. The instruction pointer advances by 6 for opcodes 0x81 and 0xC7, and by 5 for all other supported opcodes.
- R3: Opcode 0x81 takes its operation from selector bits [5:3]: 0 add, 1 or, 4 and, 5 subtract, 6 xor, 7 compare. With selector bits [7:6] = 11, the operand is the register numbered by selector bits [2:0], and the result is written back to that register.
- R4: With selector bits [7:6] = 00, the operand is the memory word addressed by the register numbered by bits [2:0]. The unit reads that word, computes, and writes the result to the same address. The memory port never reads and writes in the same cycle.
- R5: Opcodes 0x0D (or), 0x25 (and), 0x2D (subtract), 0x35 (xor) and 0x3D (compare) have no selector byte, and they operate on register 0.
- R6: Compare writes no register or memory. It sets SF to bit 31 of operand minus immediate and ZF when that difference is zero. It sets OF when the 32-bit difference differs from the exact signed difference.
- R7: Add, subtract, and, or and xor set SF and ZF from the stored result and leave OF unchanged.
- R8: Opcodes 0xB8 to 0xBF load the immediate into the register numbered by opcode bits [2:0]. The numbering is 0 EAX, 1 ECX, 2 EDX, 3 EBX, 4 ESP, 5 EBP, 6 ESI, 7 EDI.
- R9: Opcode 0xC7 writes the immediate to the register or memory operand chosen by the selector byte. Selector bits [5:3] have no effect.
- R10: Opcode 0x68 lowers register 4 by 4 and stores the immediate at the lowered address.
- R11: `done` is high for exactly one cycle per executed instruction.
- R12: An unsupported opcode, a 0x81 sub-operation of 2 or 3, or a selector mode of 01 or 10 raises `err`. The error stays set until reset, and later starts produce no `done` and do not move the instruction pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin one instruction (ignored while busy or halted) |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Sticky halt on an unsupported encoding |
| code_addr | output | 32 | Instruction pointer, address of the byte being fetched |
| code_byte | input | 8 | Instruction byte at `code_addr`, combinational |
| dmem_addr | output | 32 | Data word address |
| dmem_re | output | 1 | Read request, data returned the next cycle |
| dmem_we | output | 1 | Write strobe |
| dmem_wdata | output | 32 | Write data |
| dmem_rdata | input | 32 | Read data, valid one cycle after `dmem_re` |
| flag_sf | output | 1 | Sign flag |
| flag_zf | output | 1 | Zero flag |
| flag_of | output | 1 | Overflow flag |
| view_idx | input | 3 | Register to observe |
| view_data | output | 32 | Contents of register `view_idx` |

## Verification
Push is the one instruction whose two effects happen in the same clock edge. The stack register is lowered, and a memory write goes to the lowered address, which is computed from the value the register held before that edge. The bench sets the stack register to 0x14 with a move and then pushes twice. After each push it checks both the register and the bench's own memory at the expected word, so an address taken from the old or the twice-lowered value shows up as a miscompare. Memory read-modify-write is also checked with every register used in turn as the pointer, including the stack register.

// File: rtl/imm_exec_pkg.sv
// Shared encodings for the immediate-operand executor.
// Assumes 8-bit opcodes and a 3-bit operation field in the selector byte.
package imm_exec_pkg;

    localparam logic [2:0] OP_ADD = 3'd0;
    localparam logic [2:0] OP_OR  = 3'd1;
    localparam logic [2:0] OP_AND = 3'd4;
    localparam logic [2:0] OP_SUB = 3'd5;
    localparam logic [2:0] OP_XOR = 3'd6;
    localparam logic [2:0] OP_CMP = 3'd7;

    typedef enum logic [2:0] {
        K_BAD, K_GRP, K_MOVRM, K_MOVR, K_PUSH, K_SHORT
    } kind_e;

    typedef enum logic [3:0] {
        S_IDLE, S_OPC, S_MODRM, S_IMM, S_EXEC, S_MWAIT, S_DONE, S_HALT
    } state_e;

    // Sort an opcode byte into an instruction family.
    function automatic kind_e classify(input logic [7:0] b);
        if (b == 8'h81) return K_GRP;
        if (b == 8'hC7) return K_MOVRM;
        if (b == 8'h68) return K_PUSH;
        if (b[7:3] == 5'b10111) return K_MOVR;
        if (b[7:6] == 2'b00 && b[2:0] == 3'b101 &&
            (b[5:3] == OP_OR || b[5:3] == OP_AND || b[5:3] == OP_SUB ||
             b[5:3] == OP_XOR || b[5:3] == OP_CMP))
            return K_SHORT;
        return K_BAD;
    endfunction

    // True for the six operation codes the group opcode accepts.
    function automatic logic op_ok(input logic [2:0] s);
        return !(s == 3'd2 || s == 3'd3);
    endfunction

endpackage

// File: rtl/imm_alu.sv
// Combinational ALU for the immediate group.
// Assumes op is one of the six accepted codes; anything else passes a.
module imm_alu
    import imm_exec_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [2:0]   op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] res,
    output logic         sf,
    output logic         zf,
    output logic         of,
    output logic         writes
);
    logic [W-1:0] diff;
    logic [W-1:0] sum;

    // Result, flags and write-back qualifier.
    always_comb begin
        diff = a - b;
        sum  = a + b;
        case (op)
            OP_ADD:         res = sum;
            OP_OR:          res = a | b;
            OP_AND:         res = a & b;
            OP_SUB, OP_CMP: res = diff;
            OP_XOR:         res = a ^ b;
            default:        res = a;
        endcase
        sf = res[W-1];
        zf = (res == '0);
        if (op == OP_SUB || op == OP_CMP)
            of = (a[W-1] != b[W-1]) && (diff[W-1] != a[W-1]);
        else if (op == OP_ADD)
            of = (a[W-1] == b[W-1]) && (sum[W-1] != a[W-1]);
        else
            of = 1'b0;
        writes = (op != OP_CMP);
    end

    // A compare reports zero exactly when its operands match.
    always_comb begin
        if (op == OP_CMP)
            assert_cmp_zero_R6: assert (zf == (a == b));
    end
endmodule

// File: rtl/imm_regfile.sv
// General register file: one write port, three combinational read ports.
// Assumes synchronous active-low reset clears every entry.
module imm_regfile #(
    parameter int W = 32,
    parameter int N = 8,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [IW-1:0] widx,
    input  logic [W-1:0]  wdata,
    input  logic [IW-1:0] ridx0,
    output logic [W-1:0]  rdata0,
    input  logic [IW-1:0] ridx1,
    output logic [W-1:0]  rdata1,
    input  logic [IW-1:0] ridx2,
    output logic [W-1:0]  rdata2
);
    logic [W-1:0] regs [N];

    // Storage update with reset clear.
    always_ff @(posedge clk) begin
        for (int i = 0; i < N; i++) begin
            if (!rst_n)
                regs[i] <= '0;
            else if (we && widx == IW'(i))
                regs[i] <= wdata;
        end
    end

    // Read ports.
    assign rdata0 = regs[ridx0];
    assign rdata1 = regs[ridx1];
    assign rdata2 = regs[ridx2];

    assert_write_lands_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (we && ridx2 == widx) |=> (rdata2 == $past(wdata) || $past(ridx2) != ridx2));
endmodule

// File: rtl/imm_exec_unit.sv
// Top of the immediate-operand executor: fetch, decode, execute, memory RMW.
// Assumes code_byte is valid combinationally for code_addr, and dmem_rdata
// is valid one cycle after dmem_re. Register 4 is the stack pointer.
module imm_exec_unit
    import imm_exec_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32,
    parameter int NREG   = 8,
    parameter int SP_IDX = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    output logic                     done,
    output logic                     err,
    output logic [ADDR_W-1:0]        code_addr,
    input  logic [7:0]               code_byte,
    output logic [DATA_W-1:0]        dmem_addr,
    output logic                     dmem_re,
    output logic                     dmem_we,
    output logic [DATA_W-1:0]        dmem_wdata,
    input  logic [DATA_W-1:0]        dmem_rdata,
    output logic                     flag_sf,
    output logic                     flag_zf,
    output logic                     flag_of,
    input  logic [$clog2(NREG)-1:0]  view_idx,
    output logic [DATA_W-1:0]        view_data
);
    localparam int IMM_BYTES = DATA_W / 8;
    localparam int CNT_W     = (IMM_BYTES > 1) ? $clog2(IMM_BYTES) : 1;
    localparam int RIW       = $clog2(NREG);

    state_e             state;
    kind_e              kind_q;
    logic [7:0]         opcode;
    logic [7:0]         modrm;
    logic [DATA_W-1:0]  imm;
    logic [CNT_W-1:0]   cnt;
    logic [ADDR_W-1:0]  ip;
    logic               sf_q, zf_q, of_q;

    logic [RIW-1:0]     tgt_idx;
    logic [DATA_W-1:0]  tgt_val, sp_val;
    logic               mem_mode;
    logic [2:0]         alu_op;
    logic [DATA_W-1:0]  alu_a, alu_res;
    logic               alu_sf, alu_zf, alu_of, alu_wr;
    logic               rf_we;
    logic [RIW-1:0]     rf_widx;
    logic [DATA_W-1:0]  rf_wdata;
    logic               flag_upd;
    kind_e              kind_in;

    // Operand selection from the latched instruction.
    always_comb begin
        alu_op   = (kind_q == K_SHORT) ? opcode[5:3] : modrm[5:3];
        mem_mode = (kind_q == K_GRP || kind_q == K_MOVRM) && (modrm[7:6] == 2'b00);
        case (kind_q)
            K_SHORT:        tgt_idx = '0;
            K_MOVR:         tgt_idx = opcode[RIW-1:0];
            K_PUSH:         tgt_idx = RIW'(SP_IDX);
            default:        tgt_idx = modrm[RIW-1:0];
        endcase
        alu_a   = (state == S_MWAIT) ? dmem_rdata : tgt_val;
        kind_in = classify(code_byte);
    end

    imm_regfile #(.W(DATA_W), .N(NREG)) u_rf (
        .clk(clk), .rst_n(rst_n),
        .we(rf_we), .widx(rf_widx), .wdata(rf_wdata),
        .ridx0(tgt_idx), .rdata0(tgt_val),
        .ridx1(RIW'(SP_IDX)), .rdata1(sp_val),
        .ridx2(view_idx), .rdata2(view_data)
    );

    imm_alu #(.W(DATA_W)) u_alu (
        .op(alu_op), .a(alu_a), .b(imm),
        .res(alu_res), .sf(alu_sf), .zf(alu_zf), .of(alu_of), .writes(alu_wr)
    );

    // Write-port and memory-port control for the execute and wait states.
    always_comb begin
        rf_we      = 1'b0;
        rf_widx    = tgt_idx;
        rf_wdata   = imm;
        dmem_re    = 1'b0;
        dmem_we    = 1'b0;
        dmem_addr  = tgt_val;
        dmem_wdata = imm;
        flag_upd   = 1'b0;
        if (state == S_EXEC) begin
            case (kind_q)
                K_MOVR: rf_we = 1'b1;
                K_PUSH: begin
                    rf_we     = 1'b1;
                    rf_wdata  = sp_val - DATA_W'(IMM_BYTES);
                    dmem_we   = 1'b1;
                    dmem_addr = sp_val - DATA_W'(IMM_BYTES);
                end
                K_MOVRM: begin
                    dmem_we = mem_mode;
                    rf_we   = !mem_mode;
                end
                K_GRP, K_SHORT: begin
                    if (mem_mode) begin
                        dmem_re = 1'b1;
                    end else begin
                        rf_we    = alu_wr;
                        rf_wdata = alu_res;
                        flag_upd = 1'b1;
                    end
                end
                default: ;
            endcase
        end else if (state == S_MWAIT) begin
            dmem_we    = alu_wr;
            dmem_wdata = alu_res;
            flag_upd   = 1'b1;
        end
    end

    // Sequencer: byte fetch, immediate assembly, flag register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            kind_q <= K_BAD;
            opcode <= '0;
            modrm  <= '0;
            imm    <= '0;
            cnt    <= '0;
            ip     <= '0;
            sf_q   <= 1'b0;
            zf_q   <= 1'b0;
            of_q   <= 1'b0;
        end else begin
            if (flag_upd) begin
                sf_q <= alu_sf;
                zf_q <= alu_zf;
                if (alu_op == OP_CMP) of_q <= alu_of;
            end
            case (state)
                S_IDLE: if (start) state <= S_OPC;
                S_OPC: begin
                    opcode <= code_byte;
                    kind_q <= kind_in;
                    ip     <= ip + 1'b1;
                    cnt    <= '0;
                    if (kind_in == K_BAD)
                        state <= S_HALT;
                    else if (kind_in == K_GRP || kind_in == K_MOVRM)
                        state <= S_MODRM;
                    else
                        state <= S_IMM;
                end
                S_MODRM: begin
                    modrm <= code_byte;
                    ip    <= ip + 1'b1;
                    if (code_byte[7:6] == 2'b01 || code_byte[7:6] == 2'b10 ||
                        (kind_q == K_GRP && !op_ok(code_byte[5:3])))
                        state <= S_HALT;
                    else
                        state <= S_IMM;
                end
                S_IMM: begin
                    imm[cnt*8 +: 8] <= code_byte;
                    ip  <= ip + 1'b1;
                    cnt <= cnt + 1'b1;
                    if (cnt == CNT_W'(IMM_BYTES - 1)) state <= S_EXEC;
                end
                S_EXEC:  state <= dmem_re ? S_MWAIT : S_DONE;
                S_MWAIT: state <= S_DONE;
                S_DONE:  state <= S_IDLE;
                default: state <= S_HALT;
            endcase
        end
    end

    assign code_addr = ip;
    assign done      = (state == S_DONE);
    assign err       = (state == S_HALT);
    assign flag_sf   = sf_q;
    assign flag_zf   = zf_q;
    assign flag_of   = of_q;

    assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_err_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> (err && !done && $stable(code_addr)));
    assert_port_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(dmem_re && dmem_we));
    assert_single_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        dmem_re |=> !dmem_re);
    assert_push_lowers_sp_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (dmem_we && state == S_EXEC && kind_q == K_PUSH) |=> (sp_val == $past(dmem_addr)));
endmodule

// File: tb/sim_imm_exec_unit.sv
module sim_imm_exec_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        done, err;
    logic [31:0] code_addr;
    logic [7:0]  code_byte;
    logic [31:0] dmem_addr, dmem_wdata, dmem_rdata;
    logic        dmem_re, dmem_we;
    logic        flag_sf, flag_zf, flag_of;
    logic [2:0]  view_idx = 3'd0;
    logic [31:0] view_data;

    logic [7:0]  code_mem [1024];
    logic [31:0] dmem     [64];
    logic [31:0] exp_mem  [64];
    logic [31:0] er [8];
    logic        esf, ezf, eof;
    logic [31:0] eip;
    int nchk = 0;
    int nfail = 0;
    int cyc = 0;
    logic [31:0] va [7];
    logic [31:0] vb [7];

    always #5 clk = ~clk;

    imm_exec_unit u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .done(done), .err(err),
        .code_addr(code_addr), .code_byte(code_byte),
        .dmem_addr(dmem_addr), .dmem_re(dmem_re), .dmem_we(dmem_we),
        .dmem_wdata(dmem_wdata), .dmem_rdata(dmem_rdata),
        .flag_sf(flag_sf), .flag_zf(flag_zf), .flag_of(flag_of),
        .view_idx(view_idx), .view_data(view_data)
    );

    assign code_byte = code_mem[code_addr[9:0]];

    always @(posedge clk) begin
        if (dmem_we) dmem[dmem_addr[7:2]] <= dmem_wdata;
        if (dmem_re) dmem_rdata <= dmem[dmem_addr[7:2]];
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            nfail = nfail + 1;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk = nchk + 1;
        if (act !== exp) begin
            nfail = nfail + 1;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 8; i++) er[i] = '0;
        esf = 0; ezf = 0; eof = 0; eip = '0;
    endtask

    // Place an instruction at the expected pointer, start it, wait for the end.
    task automatic run_instr(input logic [7:0] op, input bit has_m, input logic [7:0] m,
                             input logic [31:0] imm, output bit ok);
        int n;
        n = 0;
        code_mem[10'(eip + n)] = op; n++;
        if (has_m) begin code_mem[10'(eip + n)] = m; n++; end
        for (int k = 0; k < 4; k++) begin code_mem[10'(eip + n)] = imm[8*k +: 8]; n++; end
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        ok = 0;
        for (int w = 0; w < 40; w++) begin
            if (done || err) break;
            @(negedge clk);
        end
        ok = done;
    endtask

    task automatic check_all(input string rtag, input string ftag);
        for (int r = 0; r < 8; r++) begin
            view_idx = 3'(r);
            #1;
            chk(rtag, view_data, er[r]);
        end
        chk(ftag, {29'd0, flag_sf, flag_zf, flag_of}, {29'd0, esf, ezf, eof});
        chk("R2", code_addr, eip);
    endtask

    task automatic model_alu(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b,
                             output logic [31:0] r, output bit wr);
        longint full;
        wr = 1;
        case (op)
            3'd0: r = a + b;
            3'd1: r = a | b;
            3'd4: r = a & b;
            3'd5: r = a - b;
            3'd6: r = a ^ b;
            default: begin r = a - b; wr = 0; end
        endcase
        esf = r[31];
        ezf = (r == 0);
        if (op == 3'd7) begin
            full = longint'($signed(a)) - longint'($signed(b));
            eof = (full != longint'($signed(r)));
        end
    endtask

    task automatic do_mov(input int r, input logic [31:0] v);
        bit ok;
        run_instr(8'hB8 + 8'(r), 0, 8'h00, v, ok);
        chk("R11", 32'(ok), 1);
        er[r] = v; eip = eip + 5;
        check_all("R8", "R8");
    endtask

    task automatic do_grp_reg(input logic [2:0] op, input int r, input logic [31:0] b);
        bit ok, wr;
        logic [31:0] res;
        model_alu(op, er[r], b, res, wr);
        if (wr) er[r] = res;
        run_instr(8'h81, 1, {2'b11, op, 3'(r)}, b, ok);
        chk("R11", 32'(ok), 1);
        eip = eip + 6;
        check_all("R3", (op == 3'd7) ? "R6" : "R7");
    endtask

    task automatic do_c7(input logic [7:0] m, input logic [31:0] v);
        bit ok;
        run_instr(8'hC7, 1, m, v, ok);
        chk("R11", 32'(ok), 1);
        if (m[7:6] == 2'b11) er[m[2:0]] = v;
        else exp_mem[er[m[2:0]][7:2]] = v;
        eip = eip + 6;
        check_all("R9", "R9");
        if (m[7:6] == 2'b00) chk("R9", dmem[er[m[2:0]][7:2]], v);
    endtask

    task automatic do_grp_mem(input logic [2:0] op, input int p, input logic [31:0] b);
        bit ok, wr;
        logic [31:0] res;
        logic [5:0] wi;
        wi = er[p][7:2];
        model_alu(op, exp_mem[wi], b, res, wr);
        if (wr) exp_mem[wi] = res;
        run_instr(8'h81, 1, {2'b00, op, 3'(p)}, b, ok);
        chk("R11", 32'(ok), 1);
        eip = eip + 6;
        chk("R4", dmem[wi], exp_mem[wi]);
        check_all("R4", (op == 3'd7) ? "R6" : "R7");
    endtask

    task automatic do_short(input logic [7:0] opc, input logic [31:0] b);
        bit ok, wr;
        logic [31:0] res;
        model_alu(opc[5:3], er[0], b, res, wr);
        if (wr) er[0] = res;
        run_instr(opc, 0, 8'h00, b, ok);
        chk("R11", 32'(ok), 1);
        eip = eip + 5;
        check_all("R5", (opc == 8'h3D) ? "R6" : "R7");
    endtask

    task automatic do_push(input logic [31:0] v);
        bit ok;
        run_instr(8'h68, 0, 8'h00, v, ok);
        chk("R11", 32'(ok), 1);
        er[4] = er[4] - 4;
        exp_mem[er[4][7:2]] = v;
        eip = eip + 5;
        chk("R10", dmem[er[4][7:2]], v);
        check_all("R10", "R10");
    endtask

    task automatic do_bad(input logic [7:0] op, input bit has_m, input logic [7:0] m, input int len);
        bit ok;
        logic [31:0] ip0;
        do_reset();
        run_instr(op, has_m, m, 32'h11223344, ok);
        @(negedge clk);
        chk("R12", {31'd0, err}, 1);
        chk("R12", code_addr, 32'(len));
        ip0 = code_addr;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        for (int w = 0; w < 12; w++) begin
            @(negedge clk);
            chk("R12", {31'd0, done}, 0);
        end
        chk("R12", {31'd0, err}, 1);
        chk("R12", code_addr, ip0);
    endtask

    initial begin
        logic [2:0] ops [6];
        logic [7:0] shorts [5];
        int idx;
        bit ok;
        ops = '{3'd0, 3'd1, 3'd4, 3'd5, 3'd6, 3'd7};
        shorts = '{8'h0D, 8'h25, 8'h2D, 8'h35, 8'h3D};
        va = '{32'h1, 32'h7fffffff, 32'h80000000, 32'h0, 32'hffffffff, 32'h0d0c0b0a, 32'h0d0c0b07};
        vb = '{32'h0d0c0b0a, 32'h1, 32'h1, 32'h0, 32'hffffffff, 32'h0d0c0b0a, 32'h0d0c0b0a};
        for (int i = 0; i < 64; i++) exp_mem[i] = '0;
        for (int i = 0; i < 1024; i++) code_mem[i] = 8'h00;

        do_reset();
        // R1: reset state
        @(negedge clk);
        check_all("R1", "R1");
        chk("R1", {30'd0, done, err}, 0);

        // R2: immediate byte order, via a load into EBX
        run_instr(8'hBB, 0, 8'h00, 32'h0d0c0b0a, ok);
        er[3] = 32'h0d0c0b0a; eip = eip + 5;
        view_idx = 3'd3; #1;
        chk("R2", view_data, 32'h0d0c0b0a);
        // R11: done lasts one cycle
        @(negedge clk);
        chk("R11", {31'd0, done}, 0);

        // R3 / R6 / R7: register-direct group sweep
        idx = 0;
        foreach (ops[o]) begin
            for (int v = 0; v < 7; v++) begin
                do_mov(idx % 8, va[v]);
                do_grp_reg(ops[o], idx % 8, vb[v]);
                idx++;
            end
        end

        // R4 / R9: memory read-modify-write sweep, every register as pointer
        idx = 0;
        foreach (ops[o]) begin
            for (int v = 0; v < 7; v++) begin
                do_mov(idx % 8, 32'h40 + 32'(4 * (idx % 8)));
                do_c7({2'b00, 3'(idx % 8), 3'(idx % 8)}, va[v]);
                do_grp_mem(ops[o], idx % 8, vb[v]);
                idx++;
            end
        end

        // R5: accumulator-only short forms
        foreach (shorts[s]) begin
            for (int v = 0; v < 7; v++) begin
                do_mov(0, va[v]);
                do_short(shorts[s], vb[v]);
            end
        end

        // R9: register form with a non-zero operation field
        for (int r = 0; r < 8; r++) do_c7({2'b11, 3'(7 - r), 3'(r)}, 32'hA5000000 + 32'(r));

        // R10: push lowers ESP and stores at the new top
        do_mov(4, 32'h14);
        do_push(32'h000000af);
        do_push(32'hdeadbeef);

        // R12: unsupported encodings halt
        do_bad(8'h05, 0, 8'h00, 1);
        do_bad(8'h81, 1, 8'hD3, 2);
        do_bad(8'h81, 1, 8'h43, 2);
        do_bad(8'hC7, 1, 8'h83, 2);

        $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule